// File: doc/BRIEF.md
# Timer Count Channel with Sticky Wrap Flag

This block is one counting channel of a general-purpose timer peripheral. It holds a 16-bit up-counter that advances by one on each enable pulse from a chosen count source. There are five sources: the internal prescaled tick, two external clock inputs, a tick derived from a neighbouring channel's interrupt input, and a multiplied tick from that same neighbour. Every source arrives as a single-cycle pulse that is synchronous to the system clock. When the counter wraps past its top value, a sticky flag in the status register is set. Software clears that flag with a read-then-write-zero handshake.

The channel is built in one of two clearing variants, chosen by a parameter. In the trigger variant, an increment that lands while the external clear trigger is high loads zero. In the compare variant, an increment made while the count equals the general register loads zero, but only when the control register enables compare clearing.

Software reaches the channel through a small word-only register port, and reads return data in the same cycle. A standby input forces the count back to zero.

Top module: `tmr_cnt_chan`

## Requirements
- R1: After reset, the count, status, general and control registers all read 0x0000.
- R2: Control bits [2:0] select the count source: 0 is the internal tick, 1 is external A, 2 is external B, 3 is the derived tick and 4 is the multiplied tick. Codes 5 to 7 stop counting. Pulses on unselected sources have no effect on the count.
- R3: Each selected pulse adds one to the count. An increment from 0xFFFF gives 0x0000 and sets status bit 0, the wrap flag.
- R4: The wrap flag stays set until a status write with bit 0 = 0 follows a status read that returned it as 1. A zero write without such a prior read leaves the flag set. Any status write uses up the read.
- R5: When a wrap and a valid flag clear happen in the same cycle, the flag stays set.
- R6: Trigger variant (CMP_CLEAR=0): an increment while the clear trigger is high loads 0x0000 and does not set the wrap flag, even from 0xFFFF. The trigger without an increment has no effect.
- R7: Compare variant (CMP_CLEAR=1): an increment while control bit 3 is 1 and the count equals the general register loads 0x0000. With bit 3 at 0 the count passes the match value. The clear trigger is ignored.
- R8: A bus write to the count register in the same cycle as an increment or a clear stores the written value.
- R9: Only word accesses (bus_word_i=1) take effect. A byte write changes nothing, a byte read returns 0x0000, and both raise bus_err_o during the access.
- R10: A high standby input loads 0x0000 into the count on the next edge, and this overrides a same-cycle bus write.
- R11: Register addresses are 0 = count, 1 = status, 2 = general register and 3 = control. Read data is valid in the same cycle as the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| stby_i | input | 1 | Standby, returns the count to zero |
| tick_int_i | input | 1 | Internal prescaled count enable |
| tick_ext_a_i | input | 1 | External clock A enable pulse |
| tick_ext_b_i | input | 1 | External clock B enable pulse |
| tick_drv_i | input | 1 | Derived count enable from the neighbouring channel |
| tick_mul_i | input | 1 | Multiplied count enable from the neighbouring channel |
| clr_trig_i | input | 1 | External counter-clear trigger |
| bus_sel_i | input | 1 | Register access strobe |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 1 | 1 = word access, 0 = byte access |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data |
| bus_err_o | output | 1 | Size error strobe |

## Verification
The hardest case to reach is a wrap that coincides with a flag clear that software is entitled to make. It needs the flag already set, a status read that returns 1 to arm the clear, the count preset to 0xFFFF, and then a status write of zero together with a source pulse in one cycle. The bench builds this in that order through the bus. It then reads the flag back and reruns the handshake to show the flag still clears afterwards.

Clear-versus-wrap at 0xFFFF and bus-write-versus-clear are driven the same way, with hand-timed pulses aligned to one edge. A second instance in the compare variant shares the source inputs but has its own bus.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  localparam int N_SRC = 5;
  localparam int SEL_W = 3;

  localparam logic [SEL_W-1:0] SRC_INT   = 3'd0;
  localparam logic [SEL_W-1:0] SRC_EXT_A = 3'd1;
  localparam logic [SEL_W-1:0] SRC_EXT_B = 3'd2;
  localparam logic [SEL_W-1:0] SRC_DRV   = 3'd3;
  localparam logic [SEL_W-1:0] SRC_MUL   = 3'd4;

  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_STAT = 2'd1,
    REG_GR   = 2'd2,
    REG_CTL  = 2'd3
  } tcc_reg_e;

  typedef struct packed {
    logic             clr_en;
    logic [SEL_W-1:0] src;
  } tcc_ctl_t;

  localparam int CTL_W = $bits(tcc_ctl_t);
endpackage

// File: rtl/tcc_src_sel.sv
module tcc_src_sel
  import tcc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_SRC-1:0] tick_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             inc_o
);
  logic [N_SRC-1:0] hit;

  for (genvar g = 0; g < N_SRC; g++) begin : g_src
    assign hit[g] = tick_i[g] && (sel_i == SEL_W'(g));
  end

  assign inc_o = |hit;

  // stop codes never count
  p_stop_code_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(sel_i) >= N_SRC) |-> !inc_o);
  p_inc_needs_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_o |-> (tick_i != '0));
endmodule

// File: rtl/tcc_core.sv
module tcc_core #(
  parameter int W         = 16,
  parameter bit CMP_CLEAR = 1'b0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stby_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  input  logic         clr_trig_i,
  input  logic         clr_en_i,
  input  logic [W-1:0] gr_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  localparam logic [W-1:0] TOP = '1;

  logic [W-1:0] cnt_q;
  logic         clr_hit;

  if (CMP_CLEAR) begin : g_cmp_clr
    logic unused_trig;
    assign unused_trig = clr_trig_i;
    assign clr_hit = inc_i && clr_en_i && (cnt_q == gr_i);
  end else begin : g_trig_clr
    logic unused_cmp;
    assign unused_cmp = clr_en_i ^ (^gr_i);
    assign clr_hit = inc_i && clr_trig_i;
  end

  assign wrap_o = inc_i && !clr_hit && !wr_i && !stby_i && (cnt_q == TOP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (stby_i)  cnt_q <= '0;
    else if (wr_i)    cnt_q <= wdata_i;
    else if (clr_hit) cnt_q <= '0;
    else if (inc_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;

  p_wr_wins_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !stby_i) |=> (cnt_q == $past(wdata_i)));
  p_stby_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stby_i |=> (cnt_q == '0));
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !wr_i && !stby_i) |=> $stable(cnt_q));
  p_wrap_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> (cnt_q == '0));
endmodule

// File: rtl/tcc_ovf_flag.sv
module tcc_ovf_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic rd_i,
  input  logic wr_i,
  input  logic wbit_i,
  output logic flag_o
);
  logic flag_q, arm_q, clr_req;

  assign clr_req = wr_i && !wbit_i && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_i)        flag_q <= 1'b1;
      else if (clr_req) flag_q <= 1'b0;
      if (wr_i)                 arm_q <= 1'b0;
      else if (rd_i && flag_q)  arm_q <= 1'b1;
    end
  end

  assign flag_o = flag_q;

  p_set_wins_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> flag_q);
  p_clear_needs_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(flag_q) |-> $past(wr_i && !wbit_i));
endmodule

// File: rtl/tcc_bus.sv
module tcc_bus
  import tcc_pkg::*;
#(
  parameter int W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic             word_i,
  input  logic [1:0]       addr_i,
  input  logic [W-1:0]     wdata_i,
  input  logic [W-1:0]     cnt_i,
  input  logic             flag_i,
  output logic [W-1:0]     rdata_o,
  output logic             err_o,
  output logic             cnt_wr_o,
  output logic             stat_rd_o,
  output logic             stat_wr_o,
  output logic [W-1:0]     gr_o,
  output tcc_ctl_t         ctl_o
);
  logic     ok;
  logic     rd, wr;
  logic [W-1:0] gr_q;
  tcc_ctl_t ctl_q;

  assign ok = sel_i && word_i;
  assign rd = ok && !we_i;
  assign wr = ok && we_i;

  assign cnt_wr_o  = wr && (addr_i == REG_CNT);
  assign stat_wr_o = wr && (addr_i == REG_STAT);
  assign stat_rd_o = rd && (addr_i == REG_STAT);
  assign err_o     = sel_i && !word_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gr_q  <= '0;
      ctl_q <= '0;
    end else if (wr) begin
      if (addr_i == REG_GR)  gr_q  <= wdata_i;
      if (addr_i == REG_CTL) ctl_q <= tcc_ctl_t'(wdata_i[CTL_W-1:0]);
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        REG_CNT:  rdata_o = cnt_i;
        REG_STAT: rdata_o = W'(flag_i);
        REG_GR:   rdata_o = gr_q;
        REG_CTL:  rdata_o = W'(ctl_q);
        default:  rdata_o = '0;
      endcase
    end
  end

  assign gr_o  = gr_q;
  assign ctl_o = ctl_q;

  p_byte_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !word_i) |=> ($stable(gr_q) && $stable(ctl_q)));
  p_byte_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (rdata_o == '0));
endmodule

// File: rtl/tmr_cnt_chan.sv
module tmr_cnt_chan
  import tcc_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter bit CMP_CLEAR = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stby_i,
  input  logic             tick_int_i,
  input  logic             tick_ext_a_i,
  input  logic             tick_ext_b_i,
  input  logic             tick_drv_i,
  input  logic             tick_mul_i,
  input  logic             clr_trig_i,
  input  logic             bus_sel_i,
  input  logic             bus_we_i,
  input  logic             bus_word_i,
  input  logic [1:0]       bus_addr_i,
  input  logic [CNT_W-1:0] bus_wdata_i,
  output logic [CNT_W-1:0] bus_rdata_o,
  output logic             bus_err_o
);
  logic [N_SRC-1:0] ticks;
  logic             inc, wrap, flag;
  logic             cnt_wr, stat_rd, stat_wr;
  logic [CNT_W-1:0] cnt, gr;
  tcc_ctl_t         ctl;

  // bit index equals source code
  assign ticks = {tick_mul_i, tick_drv_i, tick_ext_b_i, tick_ext_a_i, tick_int_i};

  tcc_src_sel i_src (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (ticks),
    .sel_i  (ctl.src),
    .inc_o  (inc)
  );

  tcc_core #(.W(CNT_W), .CMP_CLEAR(CMP_CLEAR)) i_core (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stby_i     (stby_i),
    .wr_i       (cnt_wr),
    .wdata_i    (bus_wdata_i),
    .inc_i      (inc),
    .clr_trig_i (clr_trig_i),
    .clr_en_i   (ctl.clr_en),
    .gr_i       (gr),
    .cnt_o      (cnt),
    .wrap_o     (wrap)
  );

  tcc_ovf_flag i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (wrap),
    .rd_i   (stat_rd),
    .wr_i   (stat_wr),
    .wbit_i (bus_wdata_i[0]),
    .flag_o (flag)
  );

  tcc_bus #(.W(CNT_W)) i_bus (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_i     (bus_sel_i),
    .we_i      (bus_we_i),
    .word_i    (bus_word_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .cnt_i     (cnt),
    .flag_i    (flag),
    .rdata_o   (bus_rdata_o),
    .err_o     (bus_err_o),
    .cnt_wr_o  (cnt_wr),
    .stat_rd_o (stat_rd),
    .stat_wr_o (stat_wr),
    .gr_o      (gr),
    .ctl_o     (ctl)
  );

  p_wrap_flags_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc && !stby_i && !cnt_wr && cnt == '1 && !(CMP_CLEAR ? (ctl.clr_en && gr == '1) : clr_trig_i))
      |=> flag);
endmodule

// File: tb/test_tmr_cnt_chan.sv
`timescale 1ns/1ps
module test_tmr_cnt_chan;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic stby = 1'b0;
  logic [4:0] tk = '0;
  logic trig = 1'b0;
  logic        sel [2];
  logic        we [2];
  logic        word [2];
  logic [1:0]  addr [2];
  logic [15:0] wd [2];
  logic [15:0] rd [2];
  logic        err [2];

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    int          u;
    logic [15:0] exp;
    logic        exp_err;
    string       tag;
  } item_t;
  item_t q[$];

  always #4 clk = ~clk;

  tmr_cnt_chan #(.CNT_W(16), .CMP_CLEAR(1'b0)) i_tmr_cnt_chan (
    .clk_i(clk), .rst_ni(rst_n), .stby_i(stby),
    .tick_int_i(tk[0]), .tick_ext_a_i(tk[1]), .tick_ext_b_i(tk[2]),
    .tick_drv_i(tk[3]), .tick_mul_i(tk[4]), .clr_trig_i(trig),
    .bus_sel_i(sel[0]), .bus_we_i(we[0]), .bus_word_i(word[0]),
    .bus_addr_i(addr[0]), .bus_wdata_i(wd[0]),
    .bus_rdata_o(rd[0]), .bus_err_o(err[0]));

  tmr_cnt_chan #(.CNT_W(16), .CMP_CLEAR(1'b1)) i_tmr_cnt_chan_cmp (
    .clk_i(clk), .rst_ni(rst_n), .stby_i(stby),
    .tick_int_i(tk[0]), .tick_ext_a_i(tk[1]), .tick_ext_b_i(tk[2]),
    .tick_drv_i(tk[3]), .tick_mul_i(tk[4]), .clr_trig_i(trig),
    .bus_sel_i(sel[1]), .bus_we_i(we[1]), .bus_word_i(word[1]),
    .bus_addr_i(addr[1]), .bus_wdata_i(wd[1]),
    .bus_rdata_o(rd[1]), .bus_err_o(err[1]));

  // monitor: compare in the middle of the access cycle
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      checks++;
      if (rd[it.u] !== it.exp || err[it.u] !== it.exp_err) begin
        errors++;
        $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                 it.tag, rd[it.u], err[it.u], it.exp, it.exp_err);
      end
    end
  end

  task automatic idle_bus();
    for (int i = 0; i < 2; i++) begin
      sel[i] = 1'b0; we[i] = 1'b0; word[i] = 1'b1; addr[i] = '0; wd[i] = '0;
    end
  endtask

  task automatic bus_wr(int u, logic [1:0] a, logic [15:0] d, logic w = 1'b1);
    @(posedge clk); #1;
    sel[u] = 1'b1; we[u] = 1'b1; word[u] = w; addr[u] = a; wd[u] = d;
    @(posedge clk); #1;
    idle_bus();
  endtask

  task automatic bus_rd(int u, logic [1:0] a, logic [15:0] e, string tag,
                        logic w = 1'b1);
    item_t it;
    @(posedge clk); #1;
    sel[u] = 1'b1; we[u] = 1'b0; word[u] = w; addr[u] = a;
    it.u = u; it.exp = e; it.exp_err = !w; it.tag = tag;
    q.push_back(it);
    @(posedge clk); #1;
    idle_bus();
  endtask

  task automatic pulse(logic [4:0] m, int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1; tk = m;
      @(posedge clk); #1; tk = '0;
    end
  endtask

  // byte write check: err seen during the access
  task automatic byte_wr_cnt(logic [15:0] d);
    item_t it;
    @(posedge clk); #1;
    sel[0] = 1'b1; we[0] = 1'b1; word[0] = 1'b0; addr[0] = 2'd0; wd[0] = d;
    it.u = 0; it.exp = 16'h0000; it.exp_err = 1'b1; it.tag = "R9 byte write err";
    q.push_back(it);
    @(posedge clk); #1;
    idle_bus();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_bus();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    bus_rd(0, 2'd0, 16'h0000, "R1 count");
    bus_rd(0, 2'd1, 16'h0000, "R1 status");
    bus_rd(0, 2'd2, 16'h0000, "R1 general");
    bus_rd(0, 2'd3, 16'h0000, "R1 control");

    // R2/R3 internal source
    pulse(5'b00001, 5);
    bus_rd(0, 2'd0, 16'd5, "R3 internal count");
    pulse(5'b11110, 2);
    bus_rd(0, 2'd0, 16'd5, "R2 unselected ignored");
    bus_wr(0, 2'd3, 16'd1);
    pulse(5'b00010, 3);
    bus_rd(0, 2'd0, 16'd8, "R2 ext A");
    bus_wr(0, 2'd3, 16'd2);
    pulse(5'b00100, 1);
    pulse(5'b00001, 1);
    bus_rd(0, 2'd0, 16'd9, "R2 ext B");
    bus_wr(0, 2'd3, 16'd3);
    pulse(5'b01000, 2);
    bus_rd(0, 2'd0, 16'd11, "R2 derived");
    bus_wr(0, 2'd3, 16'd4);
    pulse(5'b10000, 1);
    bus_rd(0, 2'd0, 16'd12, "R2 multiplied");
    bus_wr(0, 2'd3, 16'd7);
    pulse(5'b11111, 3);
    bus_rd(0, 2'd0, 16'd12, "R2 stop code");
    bus_rd(0, 2'd3, 16'd7, "R11 control readback");
    bus_wr(0, 2'd3, 16'd0);

    // R3 wrap
    bus_wr(0, 2'd0, 16'hFFFE);
    pulse(5'b00001, 1);
    bus_rd(0, 2'd1, 16'h0000, "R3 no flag before wrap");
    pulse(5'b00001, 1);
    bus_rd(0, 2'd0, 16'h0000, "R3 wrapped count");
    bus_rd(0, 2'd1, 16'h0001, "R3 flag set");

    // R4 handshake (the read above armed it; consume with a write of 1)
    bus_wr(0, 2'd1, 16'h0001);
    bus_wr(0, 2'd1, 16'h0000);
    bus_rd(0, 2'd1, 16'h0001, "R4 clear without read ignored");
    bus_wr(0, 2'd1, 16'h0000);
    bus_rd(0, 2'd1, 16'h0000, "R4 clear after read");

    // R5 set wins over clear
    bus_wr(0, 2'd0, 16'hFFFF);
    pulse(5'b00001, 1);                    // wrap -> flag 1
    bus_wr(0, 2'd0, 16'hFFFF);
    bus_rd(0, 2'd1, 16'h0001, "R5 flag armed read");
    @(posedge clk); #1;
    sel[0] = 1'b1; we[0] = 1'b1; addr[0] = 2'd1; wd[0] = 16'h0000; tk = 5'b00001;
    @(posedge clk); #1;
    idle_bus(); tk = '0;
    bus_rd(0, 2'd1, 16'h0001, "R5 set beats clear");
    bus_rd(0, 2'd0, 16'h0000, "R5 count wrapped");
    bus_wr(0, 2'd1, 16'h0000);
    bus_rd(0, 2'd1, 16'h0000, "R4 clear after R5");

    // R6 trigger clear
    bus_wr(0, 2'd0, 16'd10);
    @(posedge clk); #1 trig = 1'b1;
    @(posedge clk); #1 trig = 1'b0;
    bus_rd(0, 2'd0, 16'd10, "R6 trigger alone ignored");
    @(posedge clk); #1 trig = 1'b1; tk = 5'b00001;
    @(posedge clk); #1 trig = 1'b0; tk = '0;
    bus_rd(0, 2'd0, 16'd0, "R6 trigger with increment");
    bus_wr(0, 2'd0, 16'hFFFF);
    @(posedge clk); #1 trig = 1'b1; tk = 5'b00001;
    @(posedge clk); #1 trig = 1'b0; tk = '0;
    bus_rd(0, 2'd0, 16'd0, "R6 clear at top");
    bus_rd(0, 2'd1, 16'h0000, "R6 no flag on clear");

    // R8 bus write priority
    bus_wr(0, 2'd0, 16'd20);
    @(posedge clk); #1;
    sel[0] = 1'b1; we[0] = 1'b1; addr[0] = 2'd0; wd[0] = 16'h1234;
    tk = 5'b00001; trig = 1'b1;
    @(posedge clk); #1;
    idle_bus(); tk = '0; trig = 1'b0;
    bus_rd(0, 2'd0, 16'h1234, "R8 write beats clear");
    @(posedge clk); #1;
    sel[0] = 1'b1; we[0] = 1'b1; addr[0] = 2'd0; wd[0] = 16'h4321; tk = 5'b00001;
    @(posedge clk); #1;
    idle_bus(); tk = '0;
    bus_rd(0, 2'd0, 16'h4321, "R8 write beats increment");

    // R9 byte access
    byte_wr_cnt(16'h00AA);
    bus_rd(0, 2'd0, 16'h4321, "R9 byte write ignored");
    bus_rd(0, 2'd0, 16'h0000, "R9 byte read zero", 1'b0);
    bus_wr(0, 2'd2, 16'h0077, 1'b0);
    bus_rd(0, 2'd2, 16'h0000, "R9 byte write general ignored");

    // R10 standby beats write
    @(posedge clk); #1;
    sel[0] = 1'b1; we[0] = 1'b1; addr[0] = 2'd0; wd[0] = 16'h0099; stby = 1'b1;
    @(posedge clk); #1;
    idle_bus(); stby = 1'b0;
    bus_rd(0, 2'd0, 16'h0000, "R10 standby clears");

    // R7 compare variant
    bus_wr(1, 2'd2, 16'd5);
    bus_wr(1, 2'd3, 16'h0008);
    bus_wr(1, 2'd0, 16'd3);
    pulse(5'b00001, 2);
    bus_rd(1, 2'd0, 16'd5, "R7 reached match");
    pulse(5'b00001, 1);
    bus_rd(1, 2'd0, 16'd0, "R7 compare clear");
    bus_wr(1, 2'd0, 16'd7);
    @(posedge clk); #1 trig = 1'b1; tk = 5'b00001;
    @(posedge clk); #1 trig = 1'b0; tk = '0;
    bus_rd(1, 2'd0, 16'd8, "R7 trigger ignored");
    bus_wr(1, 2'd3, 16'h0000);
    bus_wr(1, 2'd0, 16'd5);
    pulse(5'b00001, 1);
    bus_rd(1, 2'd0, 16'd6, "R7 disabled passes match");
    bus_rd(1, 2'd2, 16'd5, "R11 general readback");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule